// File: doc/BRIEF.md
# Integer ALU with Shifts and Compares

A purely combinational integer execution unit for a load/store processor core. Two data operands, a separate shift count and an operation code enter the block, and the same evaluation produces a data result and a signed-overflow flag. The surrounding datapath picks the second operand: a register value, or an immediate that it has already zero- or sign-extended. It also supplies the shift count, taken from a constant field or from the low bits of a register. Multiply and divide are handled elsewhere.

The operation set covers wrapping and trapping add and subtract, the four bitwise operations including NOR, logical left shift, logical and arithmetic right shift, signed and unsigned set-less-than, and placement of an immediate into the upper half of the word. The overflow flag is meant to drive a trap in the pipeline. It is raised only by the trapping add and subtract. The wrapping variants give the same sum but never flag.

Top module: `int_alu`

## Requirements
- R1: Op code 0 (trapping add) and op code 1 (wrapping add) both drive result_o with (a_i + b_i) mod 2^32.
- R2: Op code 2 (trapping subtract) and op code 3 (wrapping subtract) both drive result_o with (a_i - b_i) mod 2^32.
- R3: ovf_o is 1 only for op codes 0 and 2, and only when the true two's-complement sum or difference lies outside [-2^31, 2^31-1]. For every other op code it is 0.
- R4: Op codes 4, 5 and 6 give the bitwise AND, OR and XOR of a_i and b_i.
- R5: Op code 7 gives the bitwise complement of (a_i OR b_i).
- R6: Op code 8 shifts a_i left by shamt_i (0..31) and fills the vacated low bits with zeros.
- R7: Op code 9 shifts a_i right by shamt_i and fills the vacated high bits with zeros.
- R8: Op code 10 shifts a_i right by shamt_i and fills the vacated high bits with copies of a_i[31].
- R9: Op code 11 gives 1 when a_i < b_i as two's-complement values, else 0, with bits 31..1 zero.
- R10: Op code 12 gives 1 when a_i < b_i as unsigned numbers, else 0. An all-ones a_i against b_i = 1 gives 0.
- R11: Op code 13 gives {b_i[15:0], 16'h0000}.
- R12: Op codes 14 and 15 give a result of 0 and ovf_o of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; the shifted value for shift operations |
| b_i | input | 32 | Second operand, already extended by the datapath; supplies the immediate for op 13 |
| shamt_i | input | 5 | Shift count |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of the trapping add or subtract |

## Verification
The checker evaluates several properties continuously. The overflow flag stays low outside the two trapping codes, and compare results are a single bit. The low half is zero after an upper-immediate operation, and the top bits of right shifts follow the fill rule. A difference of equal operands is zero, and the spare codes produce nothing. Only the bench's reference model shows that every full 32-bit value is correct. That covers exact overflow boundaries such as the largest positive value plus one, shifts by 0 and by 31, and the signed versus unsigned compare of all-ones against one.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDW = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBW = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHRL = 4'd9,
    OP_SHRA = 4'd10,
    OP_LTS  = 4'd11,
    OP_LTU  = 4'd12,
    OP_UPI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bw_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];
  // same input signs, different result sign
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  bw_sel_e      sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      BW_AND:  res_o = a_i & b_i;
      BW_OR:   res_o = a_i | b_i;
      BW_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stage [SH_W+1];
  logic         fill;

  // left shift = reverse, right shift, reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stage[SH_W][W-1-i];
  end

  assign fill     = arith_i & ~left_i & data_i[W-1];
  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{S{fill}}, stage[k][W-1:S]} : stage[k];
  end

  assign data_o = left_i ? rev_out : stage[SH_W];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic              do_sub;
  logic [DATA_W-1:0] sum;
  logic              carry, add_ovf;
  logic [DATA_W-1:0] bw_res, sh_res;
  bw_sel_e           bw_sel;
  logic              lt_s, lt_u;

  assign op     = alu_op_e'(op_i);
  assign do_sub = (op == OP_SUB) || (op == OP_SUBW) || (op == OP_LTS) || (op == OP_LTU);
  assign bw_sel = bw_sel_e'(op_i[1:0]);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(do_sub),
    .sum_o(sum), .carry_o(carry), .ovf_o(add_ovf)
  );

  alu_bitwise #(.W(DATA_W)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .sel_i(bw_sel), .res_o(bw_res)
  );

  alu_shifter #(.W(DATA_W), .SH_W(SH_W)) u_shifter (
    .data_i(a_i), .amt_i(shamt_i),
    .left_i(op == OP_SHL), .arith_i(op == OP_SHRA),
    .data_o(sh_res)
  );

  assign lt_s = sum[DATA_W-1] ^ add_ovf;
  assign lt_u = ~carry;

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result_o = sum;
        ovf_o    = add_ovf;
      end
      OP_ADDW, OP_SUBW:             result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: result_o = bw_res;
      OP_SHL, OP_SHRL, OP_SHRA:     result_o = sh_res;
      OP_LTS:                       result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_LTU:                       result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_UPI:                       result_o = {b_i[HALF_W-1:0], {HALF_W{1'b0}}};
      default:                      result_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [SH_W-1:0]   shamt_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    p_no_overflow_r3: assert (!(ovf_o && op_i != OP_ADD && op_i != OP_SUB))
      else $error("overflow flag outside trapping ops");
    p_sub_self_zero_r2: assert (!((op_i == OP_SUB || op_i == OP_SUBW) && a_i == b_i) || result_o == '0)
      else $error("x-x not zero");
    p_lts_one_bit_r9: assert (op_i != OP_LTS || result_o[DATA_W-1:1] == '0)
      else $error("signed compare wide");
    p_ltu_one_bit_r10: assert (op_i != OP_LTU || result_o[DATA_W-1:1] == '0)
      else $error("unsigned compare wide");
    p_upper_low_zero_r11: assert (op_i != OP_UPI || result_o[HALF_W-1:0] == '0)
      else $error("upper-immediate low half set");
    p_shrl_zero_fill_r7: assert (!(op_i == OP_SHRL && shamt_i != '0) || !result_o[DATA_W-1])
      else $error("logical shift top bit set");
    p_shra_sign_fill_r8: assert (op_i != OP_SHRA || result_o[DATA_W-1] == a_i[DATA_W-1])
      else $error("arith shift sign lost");
    p_shl_low_zero_r6: assert (!(op_i == OP_SHL && shamt_i != '0) || !result_o[0])
      else $error("left shift bit0 set");
    p_spare_quiet_r12: assert (!(op_i == OP_RSV0 || op_i == OP_RSV1) || (result_o == '0 && !ovf_o))
      else $error("spare op active");
  end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .op_i(op_i),
  .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic        ovf;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  int_alu dut_i (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .ovf_o(ovf)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R6";
      9:       return "R7";
      10:      return "R8";
      11:      return "R9";
      12:      return "R10";
      13:      return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s, output logic [31:0] r, output logic v);
    longint sx, sy, t;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r = 0;
    v = 0;
    case (o)
      0, 1: begin t = sx + sy; r = x + y; v = (o == 0) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
      2, 3: begin t = sx - sy; r = x - y; v = (o == 2) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
      4:  r = x & y;
      5:  r = x | y;
      6:  r = x ^ y;
      7:  r = ~(x | y);
      8:  r = x << s;
      9:  r = x >> s;
      10: r = 32'($signed(x) >>> s);
      11: r = (sx < sy) ? 32'd1 : 32'd0;
      12: r = (x < y) ? 32'd1 : 32'd0;
      13: r = y * 32'd65536;
      default: r = 0;
    endcase
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s);
    logic [31:0] er;
    logic        ev;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    model(o, x, y, s, er, ev);
    @(posedge clk);
    #1;
    n_cmp++;
    if (res !== er || ovf !== ev) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b expected res=%h ovf=%b",
               req_of(o), o, x, y, s, res, ovf, er, ev);
    end
  endtask

  initial begin
    a = 0; b = 0; sh = 0; op = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1: idle inputs after reset give zero sum, no flag
    apply(4'd0, 32'h0, 32'h0, 5'd0);
    // R1/R3: overflow corners
    apply(4'd0, 32'h7fff_ffff, 32'h1, 5'd0);
    apply(4'd1, 32'h7fff_ffff, 32'h1, 5'd0);
    apply(4'd0, 32'h8000_0000, 32'hffff_ffff, 5'd0);
    apply(4'd0, 32'hffff_ffff, 32'h1, 5'd0);
    // R2/R3
    apply(4'd2, 32'h8000_0000, 32'h1, 5'd0);
    apply(4'd3, 32'h8000_0000, 32'h1, 5'd0);
    apply(4'd2, 32'h7fff_ffff, 32'hffff_ffff, 5'd0);
    apply(4'd2, 32'h1234_5678, 32'h1234_5678, 5'd0);
    // R5
    apply(4'd7, 32'h0f0f_0000, 32'h00f0_00ff, 5'd0);
    // R6/R7/R8 shift edges
    apply(4'd8, 32'h8000_0001, 32'h0, 5'd31);
    apply(4'd9, 32'h8000_0000, 32'h0, 5'd31);
    apply(4'd10, 32'h8000_0000, 32'h0, 5'd31);
    apply(4'd10, 32'h8765_4321, 32'h0, 5'd0);
    apply(4'd10, 32'h4000_0000, 32'h0, 5'd4);
    // R9/R10: all-ones versus one
    apply(4'd11, 32'hffff_ffff, 32'h1, 5'd0);
    apply(4'd12, 32'hffff_ffff, 32'h1, 5'd0);
    apply(4'd11, 32'h2, 32'h1, 5'd0);
    apply(4'd12, 32'h1, 32'h2, 5'd0);
    apply(4'd11, 32'h8000_0000, 32'h7fff_ffff, 5'd0);
    apply(4'd12, 32'h5, 32'h5, 5'd0);
    // R11
    apply(4'd13, 32'hdead_beef, 32'hffff_abcd, 5'd7);
    // R12
    apply(4'd14, 32'hffff_ffff, 32'hffff_ffff, 5'd3);
    apply(4'd15, 32'h7fff_ffff, 32'h1, 5'd1);
    // R4 and all others: broad patterns
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 7 == 0) x = {x[31], {31{x[30]}}};
      if (i % 11 == 0) y = 32'h8000_0000 ^ (y & 32'h3);
      apply(4'(i % 16), x, y, 5'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule